// File: doc/BRIEF.md
# Guarded Child-Counter Decrement Unit

This unit carries out one privileged operation: it lowers a 64-bit "virtual child" counter that belongs to a parent control page. Before it touches the counter, it runs a fixed, prioritised chain of checks on a target page address and on the address of the parent control page. It uses lookup results from a page-metadata table, which the surrounding logic supplies: whether each address is in the protected region, and for the target its valid bit, page type, recorded owner and whether it is being modified.

The chain mixes hard faults with soft failures. A failed check either raises a general-protection fault (error code 0) or a page fault carrying the offending address, or it completes with a result code and the zero flag set. The counter itself is held inside the unit, one per parent, in a small register array. Underflow is found by decrementing first and then restoring the counter, so a failed attempt costs one extra cycle.

A one-cycle start pulse launches an operation. Every input is captured at that start pulse. A one-cycle done pulse marks the completion. The fault, result, flag and counter outputs are valid from the done pulse on and hold until the next completion.

Top module: `child_count_dec`

## Requirements
- R1: A privilege level other than 0 raises a general-protection fault ahead of every other check. It reports fault_addr 0.
- R2: A target address whose low 12 bits are not all zero raises a general-protection fault with fault_addr 0. This check follows R1.
- R3: A target outside the protected region raises a page fault with fault_addr equal to the target. Otherwise, a parent outside the region raises a page fault with fault_addr equal to the parent.
- R4: A target marked busy completes without a fault. It gives result code 1 and ZF=1, and leaves the counter unchanged. This check comes before the valid check.
- R5: A target whose valid bit is 0 raises a page fault on the target address.
- R6: Page types 0, 1 and 2 resolve the parent to the recorded owner. Type 3 (control page) resolves it to the target address itself. Types 4 to 7 raise a page fault on the target.
- R7: A resolved parent that differs from the supplied parent address raises a general-protection fault, and the counter is left unchanged.
- R8: On success the counter of the parent is decremented by one, the result code is 0 and ZF=0. cnt_o shows the new value.
- R9: A decrement of a zero counter restores it to 0 and completes with result code 2 and ZF=1. cnt_o shows 0.
- R10: Every non-faulting completion clears CF, PF, AF, SF and OF. The flag layout is bit0 CF, bit1 PF, bit2 AF, bit3 ZF, bit4 SF, bit5 OF.
- R11: A faulting completion leaves the result code and the counter unchanged, and passes flags_in through to flags_out unchanged.
- R12: done is a single-cycle pulse. Counting clock edges after the edge that samples start, it rises after 2 edges for a fault or conflict, after 3 edges for success and after 4 edges for underflow.
- R13: A start pulse that arrives while an operation is in progress is ignored.
- R14: Each of the NPAR counters resets to INIT_CNT. The counters are independent of each other, and each is selected by parent address bits [12 +: log2(NPAR)].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse |
| priv | input | 2 | Current privilege level |
| tgt_addr | input | ADDR_W | Target page address |
| par_addr | input | ADDR_W | Supplied parent control page address |
| tgt_in_rgn | input | 1 | Target lies in protected region |
| par_in_rgn | input | 1 | Parent lies in protected region |
| tgt_busy | input | 1 | Target is being modified elsewhere |
| tgt_valid | input | 1 | Target metadata valid bit |
| tgt_type | input | 3 | Target page type |
| tgt_owner | input | ADDR_W | Recorded owning parent of target |
| flags_in | input | 6 | Incoming status flags |
| done | output | 1 | Completion pulse |
| fault_gp | output | 1 | General-protection fault of last completion |
| fault_pf | output | 1 | Page fault of last completion |
| fault_addr | output | ADDR_W | Faulting address (0 for general protection) |
| result | output | RES_W | Result code |
| flags_out | output | 6 | Status flags after completion |
| cnt_o | output | CNT_W | Counter value after a decrement attempt |

## Verification
A wrong check order shows up at done as the wrong fault kind or the wrong fault address. Examples are a page fault where a conflict was due, or a parent-address page fault that masks a target fault. Both appear at the first completion with overlapping error conditions. A corrupted counter, such as a missing restore after underflow or a decrement on a faulting path, is not visible at once. It shows as a wrong cnt_o value, or as a wrong success or underflow outcome, on the next decrement of the same parent, so the tests chain operations per parent. A stuck or early-exiting state machine shows as a changed done latency, or as a second done pulse after an ignored start.

// File: rtl/child_count_dec.sv
module child_count_dec #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 64,
  parameter int NPAR       = 4,
  parameter int RES_W      = 8,
  parameter int PAGE_SHIFT = 12,
  parameter int INIT_CNT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        priv,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [ADDR_W-1:0] par_addr,
  input  logic              tgt_in_rgn,
  input  logic              par_in_rgn,
  input  logic              tgt_busy,
  input  logic              tgt_valid,
  input  logic [2:0]        tgt_type,
  input  logic [ADDR_W-1:0] tgt_owner,
  input  logic [5:0]        flags_in,
  output logic              done,
  output logic              fault_gp,
  output logic              fault_pf,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [RES_W-1:0]  result,
  output logic [5:0]        flags_out,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int IDX_W = (NPAR > 1) ? $clog2(NPAR) : 1;
  localparam logic [2:0] TY_CTRL = 3'd3;
  localparam logic [RES_W-1:0] RC_OK = '0;
  localparam logic [RES_W-1:0] RC_CONFLICT = RES_W'(1);
  localparam logic [RES_W-1:0] RC_UNDERFLOW = RES_W'(2);
  localparam logic [5:0] ZF_ONLY = 6'b001000;

  typedef enum logic [1:0] {S_IDLE, S_CHK, S_DEC, S_FIX} st_t;
  st_t st;

  logic [1:0]        l_priv;
  logic [ADDR_W-1:0] l_tgt, l_par, l_owner;
  logic              l_tin, l_pin, l_busy, l_valid;
  logic [2:0]        l_type;
  logic [5:0]        l_flags;
  logic [CNT_W-1:0]  cnt_q [NPAR];

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] resolved;
  logic              f_gp, f_pf, conflict;
  logic [ADDR_W-1:0] f_addr;
  logic [CNT_W-1:0]  cur;

  assign idx      = l_par[PAGE_SHIFT +: IDX_W];
  assign resolved = (l_type == TY_CTRL) ? l_tgt : l_owner;
  assign cur      = cnt_q[idx];

  always_comb begin
    f_gp = 1'b0; f_pf = 1'b0; conflict = 1'b0; f_addr = '0;
    if (l_priv != 2'd0)                   f_gp = 1'b1;
    else if (|l_tgt[PAGE_SHIFT-1:0])      f_gp = 1'b1;
    else if (!l_tin)                      begin f_pf = 1'b1; f_addr = l_tgt; end
    else if (!l_pin)                      begin f_pf = 1'b1; f_addr = l_par; end
    else if (l_busy)                      conflict = 1'b1;
    else if (!l_valid)                    begin f_pf = 1'b1; f_addr = l_tgt; end
    else if (l_type > TY_CTRL)            begin f_pf = 1'b1; f_addr = l_tgt; end
    else if (resolved != l_par)           f_gp = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; fault_gp <= 1'b0; fault_pf <= 1'b0;
      fault_addr <= '0; result <= '0; flags_out <= '0; cnt_o <= '0;
      l_priv <= '0; l_tgt <= '0; l_par <= '0; l_owner <= '0; l_tin <= 1'b0;
      l_pin <= 1'b0; l_busy <= 1'b0; l_valid <= 1'b0; l_type <= '0; l_flags <= '0;
      for (int i = 0; i < NPAR; i++) cnt_q[i] <= CNT_W'(INIT_CNT);
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          l_priv <= priv; l_tgt <= tgt_addr; l_par <= par_addr; l_owner <= tgt_owner;
          l_tin <= tgt_in_rgn; l_pin <= par_in_rgn; l_busy <= tgt_busy;
          l_valid <= tgt_valid; l_type <= tgt_type; l_flags <= flags_in;
          st <= S_CHK;
        end
        S_CHK: begin
          if (f_gp || f_pf) begin
            done <= 1'b1; fault_gp <= f_gp; fault_pf <= f_pf; fault_addr <= f_addr;
            flags_out <= l_flags; st <= S_IDLE;
          end else if (conflict) begin
            done <= 1'b1; fault_gp <= 1'b0; fault_pf <= 1'b0; fault_addr <= '0;
            result <= RC_CONFLICT; flags_out <= ZF_ONLY; st <= S_IDLE;
          end else begin
            st <= S_DEC;
          end
        end
        S_DEC: begin
          cnt_q[idx] <= cur - 1'b1;
          if (cur == '0) st <= S_FIX;
          else begin
            done <= 1'b1; fault_gp <= 1'b0; fault_pf <= 1'b0; fault_addr <= '0;
            result <= RC_OK; flags_out <= '0; cnt_o <= cur - 1'b1; st <= S_IDLE;
          end
        end
        S_FIX: begin
          cnt_q[idx] <= cur + 1'b1;
          done <= 1'b1; fault_gp <= 1'b0; fault_pf <= 1'b0; fault_addr <= '0;
          result <= RC_UNDERFLOW; flags_out <= ZF_ONLY; cnt_o <= cur + 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_one_fault_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_gp, fault_pf}));

  p_fault_keeps_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK && (f_gp || f_pf)) |=> (done && $stable(result)));

  p_wrap_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIX) |-> (cur == '1));

  p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIX) |=> (done && cnt_o == '0 && result == RC_UNDERFLOW && flags_out[3]));

  p_arith_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault_gp && !fault_pf) |-> (flags_out[5:4] == 2'b00 && flags_out[2:0] == 3'b000));

  p_ignore_busy_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start) |=> $stable(l_par));
endmodule

// File: tb/child_count_dec_tb.sv
module child_count_dec_tb;
  localparam int AW = 32;
  localparam int CW = 64;
  localparam logic [5:0] FIN = 6'h3F;
  localparam logic [5:0] ZFO = 6'b001000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] priv = '0;
  logic [AW-1:0] tgt_addr = '0, par_addr = '0, tgt_owner = '0;
  logic tgt_in_rgn = 1'b0, par_in_rgn = 1'b0, tgt_busy = 1'b0, tgt_valid = 1'b0;
  logic [2:0] tgt_type = '0;
  logic [5:0] flags_in = '0;
  logic done, fault_gp, fault_pf;
  logic [AW-1:0] fault_addr;
  logic [7:0] result;
  logic [5:0] flags_out;
  logic [CW-1:0] cnt_o;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  child_count_dec u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .priv(priv), .tgt_addr(tgt_addr),
    .par_addr(par_addr), .tgt_in_rgn(tgt_in_rgn), .par_in_rgn(par_in_rgn),
    .tgt_busy(tgt_busy), .tgt_valid(tgt_valid), .tgt_type(tgt_type),
    .tgt_owner(tgt_owner), .flags_in(flags_in), .done(done), .fault_gp(fault_gp),
    .fault_pf(fault_pf), .fault_addr(fault_addr), .result(result),
    .flags_out(flags_out), .cnt_o(cnt_o));

  function automatic logic [AW-1:0] pg(input int i);
    return 32'h8000_0000 + (AW'(i) << 12);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] pv, input logic [AW-1:0] t, input logic [AW-1:0] p,
                    input bit tin, input bit pin, input bit bsy, input bit vld,
                    input logic [2:0] ty, input logic [AW-1:0] own, output int lat);
    @(negedge clk);
    priv = pv; tgt_addr = t; par_addr = p; tgt_in_rgn = tin; par_in_rgn = pin;
    tgt_busy = bsy; tgt_valid = vld; tgt_type = ty; tgt_owner = own; flags_in = FIN;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
  endtask

  task automatic expect_out(input string req, input int lat, input int elat,
                            input bit egp, input bit epf, input logic [AW-1:0] eaddr,
                            input logic [7:0] eres, input logic [5:0] efl,
                            input bit use_cnt, input logic [CW-1:0] ecnt);
    chk(lat == elat, {req, " latency"}, 64'(lat), 64'(elat));
    chk(fault_gp == egp && fault_pf == epf, {req, " fault kind"}, {fault_gp, fault_pf}, {egp, epf});
    chk(fault_addr == eaddr, {req, " fault addr"}, 64'(fault_addr), 64'(eaddr));
    chk(result == eres, {req, " result"}, 64'(result), 64'(eres));
    chk(flags_out == efl, {req, " flags"}, 64'(flags_out), 64'(efl));
    if (use_cnt) chk(cnt_o == ecnt, {req, " counter"}, cnt_o, ecnt);
    @(negedge clk);
    chk(!done, "R12 done single cycle", 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    chk(!done && !fault_gp && !fault_pf && result == 0 && flags_out == 0 && cnt_o == 0,
        "R14 reset state", {done, fault_gp, fault_pf, result, flags_out}, 64'd0);
  endtask

  task automatic t_priv;
    int lat;
    op(2'd3, 32'h8000_0123, pg(0), 0, 0, 1, 0, 3'd6, 0, lat);
    expect_out("R1 privilege", lat, 2, 1, 0, 0, 8'd0, FIN, 0, 0);
  endtask

  task automatic t_align;
    int lat;
    op(2'd0, 32'h8000_0010, pg(0), 0, 0, 1, 1, 3'd0, pg(0), lat);
    expect_out("R2 misaligned", lat, 2, 1, 0, 0, 8'd0, FIN, 0, 0);
  endtask

  task automatic t_region;
    int lat;
    op(2'd0, pg(0), pg(1), 0, 0, 1, 1, 3'd0, pg(1), lat);
    expect_out("R3 target outside", lat, 2, 0, 1, pg(0), 8'd0, FIN, 0, 0);
    op(2'd0, pg(0), pg(1), 1, 0, 1, 0, 3'd0, pg(1), lat);
    expect_out("R3 parent outside", lat, 2, 0, 1, pg(1), 8'd0, FIN, 0, 0);
  endtask

  task automatic t_conflict;
    int lat;
    op(2'd0, pg(8), pg(0), 1, 1, 1, 0, 3'd7, pg(0), lat);
    expect_out("R4 R10 conflict", lat, 2, 0, 0, 0, 8'd1, ZFO, 0, 0);
  endtask

  task automatic t_invalid;
    int lat;
    op(2'd0, pg(8), pg(0), 1, 1, 0, 0, 3'd0, pg(0), lat);
    expect_out("R5 R11 invalid", lat, 2, 0, 1, pg(8), 8'd1, FIN, 0, 0);
  endtask

  task automatic t_badtype;
    int lat;
    op(2'd0, pg(8), pg(0), 1, 1, 0, 1, 3'd5, pg(0), lat);
    expect_out("R6 bad type", lat, 2, 0, 1, pg(8), 8'd1, FIN, 0, 0);
  endtask

  task automatic t_mismatch;
    int lat;
    op(2'd0, pg(8), pg(0), 1, 1, 0, 1, 3'd0, pg(2), lat);
    expect_out("R7 owner mismatch", lat, 2, 1, 0, 0, 8'd1, FIN, 0, 0);
    op(2'd0, pg(3), pg(0), 1, 1, 0, 1, 3'd3, pg(0), lat);
    expect_out("R6 R7 control page self", lat, 2, 1, 0, 0, 8'd1, FIN, 0, 0);
  endtask

  task automatic t_success_and_underflow;
    int lat;
    op(2'd0, pg(8), pg(0), 1, 1, 0, 1, 3'd0, pg(0), lat);
    expect_out("R8 R4 R7 parent0 after faults", lat, 3, 0, 0, 0, 8'd0, 6'd0, 1, 64'd1);
    op(2'd0, pg(9), pg(1), 1, 1, 0, 1, 3'd2, pg(1), lat);
    expect_out("R8 trimmed page", lat, 3, 0, 0, 0, 8'd0, 6'd0, 1, 64'd1);
    op(2'd0, pg(1), pg(1), 1, 1, 0, 1, 3'd3, pg(7), lat);
    expect_out("R6 R8 control page", lat, 3, 0, 0, 0, 8'd0, 6'd0, 1, 64'd0);
    op(2'd0, pg(9), pg(1), 1, 1, 0, 1, 3'd1, pg(1), lat);
    expect_out("R9 R10 underflow", lat, 4, 0, 0, 0, 8'd2, ZFO, 1, 64'd0);
    op(2'd0, pg(9), pg(1), 1, 1, 0, 1, 3'd0, pg(1), lat);
    expect_out("R9 restore holds", lat, 4, 0, 0, 0, 8'd2, ZFO, 1, 64'd0);
    op(2'd0, pg(10), pg(2), 1, 1, 0, 1, 3'd1, pg(2), lat);
    expect_out("R14 independent parent", lat, 3, 0, 0, 0, 8'd0, 6'd0, 1, 64'd1);
  endtask

  task automatic t_busy_start;
    int lat, extra;
    @(negedge clk);
    priv = 0; tgt_addr = pg(11); par_addr = pg(3); tgt_in_rgn = 1; par_in_rgn = 1;
    tgt_busy = 0; tgt_valid = 1; tgt_type = 3'd0; tgt_owner = pg(3); flags_in = FIN;
    start = 1'b1;
    @(negedge clk);
    lat = 1;
    tgt_addr = pg(12); par_addr = pg(2); tgt_owner = pg(2);
    @(negedge clk);
    start = 1'b0; lat = 2;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    expect_out("R13 first op kept", lat, 3, 0, 0, 0, 8'd0, 6'd0, 1, 64'd1);
    extra = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (done) extra++; end
    chk(extra == 0, "R13 no second done", 64'(extra), 64'd0);
    op(2'd0, pg(12), pg(2), 1, 1, 0, 1, 3'd0, pg(2), lat);
    expect_out("R13 parent2 untouched", lat, 3, 0, 0, 0, 8'd0, 6'd0, 1, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_priv;
    t_align;
    t_region;
    t_conflict;
    t_invalid;
    t_badtype;
    t_mismatch;
    t_success_and_underflow;
    t_busy_start;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule